// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers interrupt events from a fixed set of sources (by default a USB event, a timer 0 overflow and a timer 1 overflow) and turns them into one request and one vector address for a CPU sequencer. Each source pulse sets a sticky pending flag. The flag stays set until the CPU services that source or software writes it to zero. A global enable and one enable per source decide which pending flags may be issued.

Sources are not looked at continuously. The block watches a phase strobe from the CPU and arbitrates only on its rising edge, once per instruction cycle. Any flag that became pending since the previous rising edge is considered at the next one. When several flags are eligible, the lowest source index wins. Its vector is presented together with the request until the CPU acknowledges it. The acknowledge clears the serviced flag and the global enable, so a second interrupt cannot nest until software sets the enable again.

Software sees all state through a single control word. Bit 0 holds the global enable. Bits 3:1 hold the source enables, with bit 1 for source 0. Bits 6:4 hold the pending flags, with bit 4 for source 0.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source 0 (USB) has the highest priority. When its flag is eligible at an arbitration edge, it is issued with vector 0x04.
- R2: Source 1 (timer 0 overflow) vectors to 0x08 and beats source 2. Source 2 (timer 1 overflow) vectors to 0x0C and is issued only when no higher source is eligible.
- R3: Arbitration happens only in a cycle where the strobe is high after having been low in the previous cycle. A flag already pending in that cycle raises the request one clock later.
- R4: A pending flag stays set through any number of strobes until an acknowledge of that source, or a control write with that flag bit at 0.
- R5: While the global enable (control bit 0) is 0, the request output is low and no source is issued, even with pending flags. Writing the enable to 0 withdraws a request that is already presented.
- R6: A source whose enable bit is 0 is never issued, but its flag stays pending.
- R7: An acknowledge while the request is high clears the flag of the issued source and the global enable in the next cycle. Other pending flags are kept.
- R8: At most one source is issued per arbitration edge. Request and vector hold steady until acknowledge or a control write. A higher source that becomes pending meanwhile does not replace the issued one.
- R9: A source pulse in the same cycle as a control write that clears its flag leaves the flag set.
- R10: After reset the control word reads 0, the request is low and the vector is 0.
- R11: A control write replaces all seven control bits, and the read port shows the written value in the next cycle. The vector output is 0 whenever the request is low.
- R12: An acknowledge while no request is presented changes nothing.
- R13: A strobe held high for several cycles causes only one arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| phase_i | input | 1 | Instruction-cycle phase strobe; rising edge triggers arbitration |
| src_pulse_i | input | 3 | One-cycle event pulses, bit n for source n |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 7 | Control word write value |
| rd_data_o | output | 7 | Current control word |
| ack_i | input | 1 | CPU acknowledge of the presented request |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 8 | Vector address of the issued source |

## Verification
The bench builds the block with its defaults: three sources, vector base 4 and stride 4. With these values each of the three priority levels and each of the three vector addresses can be hit. Directed sequences cover the collisions: two sources pending at one edge, a higher source arriving while a lower one is held, a set pulse colliding with a software clear, and an enable dropped while a request is presented. Random strobe, pulse, write and acknowledge traffic is compared cycle by cycle against a behavioural model in the bench.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    // Control word layout: [0] global enable, then source enables, then flags.
    localparam int unsigned GIE_POS = 0;
    localparam int unsigned EN_LSB  = 1;

    function automatic int unsigned flag_lsb(input int unsigned n_src);
        return EN_LSB + n_src;
    endfunction

    function automatic int unsigned ctrl_width(input int unsigned n_src);
        return 2 * n_src + 1;
    endfunction

endpackage

// File: rtl/irqv_phase_edge.sv
module irqv_phase_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic phase_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = phase_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = phase_i & ~st_q.prev;

endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick #(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned IDX_W   = 2
) (
    input  logic [NUM_SRC-1:0] elig_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Lowest index wins: scan downward so the last hit is the highest priority.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqv_vec_map.sv
module irqv_vec_map #(
    parameter int unsigned NUM_SRC    = 3,
    parameter int unsigned IDX_W      = 2,
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned VEC_BASE   = 4,
    parameter int unsigned VEC_STRIDE = 4
) (
    input  logic             valid_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [VEC_W-1:0] vec_o
);
    logic [VEC_W-1:0] table_w [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_tbl
        assign table_w[g] = VEC_W'(VEC_BASE + VEC_STRIDE * g);
    end

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (valid_i && (idx_i == IDX_W'(i))) vec_o = table_w[i];
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int unsigned NUM_SRC    = 3,
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned VEC_BASE   = 4,
    parameter int unsigned VEC_STRIDE = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 phase_i,
    input  logic [NUM_SRC-1:0]   src_pulse_i,
    input  logic                 wr_en_i,
    input  logic [2*NUM_SRC:0]   wr_data_i,
    output logic [2*NUM_SRC:0]   rd_data_o,
    input  logic                 ack_i,
    output logic                 irq_req_o,
    output logic [VEC_W-1:0]     irq_vec_o
);
    import irqv_pkg::*;

    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int unsigned CTRL_W = ctrl_width(NUM_SRC);
    localparam int unsigned FL_LSB = flag_lsb(NUM_SRC);

    typedef struct packed {
        logic               gie;
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] flag;
        logic               req;
        logic [IDX_W-1:0]   sel;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;

    logic             strobe_rise;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;

    irqv_phase_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phase_i (phase_i),
        .rise_o  (strobe_rise)
    );

    irqv_prio_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_pick (
        .elig_i (s_q.flag & s_q.en),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    irqv_vec_map #(
        .NUM_SRC    (NUM_SRC),
        .IDX_W      (IDX_W),
        .VEC_W      (VEC_W),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE)
    ) u_vec (
        .valid_i (s_q.req),
        .idx_i   (s_q.sel),
        .vec_o   (irq_vec_o)
    );

    always_comb begin
        s_d = s_q;

        // Software access replaces the whole control word.
        if (wr_en_i) begin
            s_d.gie  = wr_data_i[GIE_POS];
            s_d.en   = wr_data_i[EN_LSB +: NUM_SRC];
            s_d.flag = wr_data_i[FL_LSB +: NUM_SRC];
        end

        // Service: retire the issued flag and close the global enable.
        if (ack_i && s_q.req) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (s_q.sel == IDX_W'(i)) s_d.flag[i] = 1'b0;
            end
            s_d.gie = 1'b0;
            s_d.req = 1'b0;
        end

        // New events always win over any clear in the same cycle.
        s_d.flag = s_d.flag | src_pulse_i;

        // One arbitration per strobe rising edge, only when idle.
        if (strobe_rise && s_q.gie && !s_q.req && pick_any) begin
            s_d.req = 1'b1;
            s_d.sel = pick_idx;
        end

        if (!s_d.gie) s_d.req = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign irq_req_o = s_q.req;
    assign rd_data_o = CTRL_W'({s_q.flag, s_q.en, s_q.gie});

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned VEC_W   = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               phase_i,
    input logic [NUM_SRC-1:0] src_pulse_i,
    input logic               wr_en_i,
    input logic               ack_i,
    input logic [2*NUM_SRC:0] rd_data_o,
    input logic               irq_req_o,
    input logic [VEC_W-1:0]   irq_vec_o
);
    AST_REQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req_o |-> rd_data_o[0]); // R5

    AST_VEC_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req_o |-> (irq_vec_o != '0)); // R1

    AST_VEC_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_req_o |-> (irq_vec_o == '0)); // R11

    AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_req_o && !ack_i && !wr_en_i) |=> (irq_req_o && $stable(irq_vec_o))); // R8

    AST_ACK_CLOSES_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_req_o && ack_i) |=> !rd_data_o[0]); // R7

    AST_RISE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_req_o) |-> $past(phase_i)); // R3

    AST_IDLE_ACK_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !irq_req_o && !wr_en_i && (src_pulse_i == '0)) |=> $stable(rd_data_o)); // R12

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        AST_PULSE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
            src_pulse_i[g] |=> rd_data_o[NUM_SRC + 1 + g]); // R9

        AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rd_data_o[NUM_SRC + 1 + g] && !wr_en_i && !ack_i) |=> rd_data_o[NUM_SRC + 1 + g]); // R4
    end

endmodule

bind irq_vector_ctrl irqv_checker #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase_i),
    .src_pulse_i (src_pulse_i),
    .wr_en_i     (wr_en_i),
    .ack_i       (ack_i),
    .rd_data_o   (rd_data_o),
    .irq_req_o   (irq_req_o),
    .irq_vec_o   (irq_vec_o)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         phase = 1'b0;
    logic [N-1:0] pulse = '0;
    logic         wr = 1'b0;
    logic [6:0]   wdata = '0;
    logic         ack = 1'b0;
    logic [6:0]   rd;
    logic         req;
    logic [7:0]   vec;

    int n_chk = 0;
    int n_fail = 0;

    // Behavioural model state
    logic       m_gie = 1'b0;
    logic [2:0] m_en = '0;
    logic [2:0] m_flag = '0;
    logic       m_req = 1'b0;
    int         m_sel = 0;
    logic       m_ph = 1'b0;

    always #4 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .phase_i     (phase),
        .src_pulse_i (pulse),
        .wr_en_i     (wr),
        .wr_data_i   (wdata),
        .rd_data_o   (rd),
        .ack_i       (ack),
        .irq_req_o   (req),
        .irq_vec_o   (vec)
    );

    function automatic logic [7:0] vec_of(input logic r, input int s);
        return r ? 8'(4 + 4 * s) : 8'h00;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic ph, input logic [2:0] p, input logic w,
                              input logic [6:0] wd, input logic a);
        logic       g, rq, rise;
        logic [2:0] e, f;
        int         s;
        rise = ph && !m_ph;
        g = m_gie; e = m_en; f = m_flag; rq = m_req; s = m_sel;
        if (w) begin
            g = wd[0]; e = wd[3:1]; f = wd[6:4];
        end
        if (a && m_req) begin
            f[m_sel] = 1'b0; g = 1'b0; rq = 1'b0;
        end
        f = f | p;
        if (rise && m_gie && !m_req && ((m_flag & m_en) != 3'b000)) begin
            rq = 1'b1;
            if ((m_flag[0] & m_en[0]) == 1'b1)      s = 0;
            else if ((m_flag[1] & m_en[1]) == 1'b1) s = 1;
            else                                    s = 2;
        end
        if (!g) rq = 1'b0;
        m_gie = g; m_en = e; m_flag = f; m_req = rq; m_sel = s; m_ph = ph;
    endtask

    // One clock: drive at negedge, step model at posedge, compare at next negedge.
    task automatic cyc(input logic ph, input logic [2:0] p, input logic w,
                       input logic [6:0] wd, input logic a);
        phase = ph; pulse = p; wr = w; wdata = wd; ack = a;
        @(posedge clk);
        model_step(ph, p, w, wd, a);
        @(negedge clk);
        check("R8 model", {15'd0, req, vec, rd},
              {15'd0, m_req, vec_of(m_req, m_sel), m_flag, m_en, m_gie});
    endtask

    task automatic finish_run;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1_200_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = 32'h1bad5eed;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        check("R10 rd", 32'(rd), 32'h00);
        check("R10 req", 32'(req), 32'h0);
        check("R10 vec", 32'(vec), 32'h00);
        rst_n = 1'b1;

        cyc(0, 3'b000, 1, 7'h0F, 0);
        check("R11 readback", 32'(rd), 32'h0F);

        cyc(0, 3'b110, 0, 7'h00, 0);
        check("R4 flags set", 32'(rd), 32'h6F);
        check("R3 no strobe no req", 32'(req), 32'h0);

        cyc(1, 3'b000, 0, 7'h00, 0);
        check("R3 req after edge", 32'(req), 32'h1);
        check("R2 src1 beats src2", 32'(vec), 32'h08);

        cyc(1, 3'b000, 0, 7'h00, 0);
        cyc(0, 3'b000, 0, 7'h00, 0);
        cyc(1, 3'b001, 0, 7'h00, 0);
        check("R8 no preempt", 32'(vec), 32'h08);
        check("R13 held", 32'(req), 32'h1);

        cyc(0, 3'b000, 0, 7'h00, 1);
        check("R7 req drop", 32'(req), 32'h0);
        check("R7 flag and gie cleared", 32'(rd), 32'h5E);

        cyc(1, 3'b000, 0, 7'h00, 0);
        check("R5 gie off", 32'(req), 32'h0);
        cyc(0, 3'b000, 0, 7'h00, 0);

        cyc(0, 3'b000, 1, 7'h5F, 0);
        cyc(1, 3'b000, 0, 7'h00, 0);
        check("R1 src0 vector", 32'(vec), 32'h04);
        cyc(0, 3'b000, 0, 7'h00, 1);
        check("R7 other flag kept", 32'(rd), 32'h4E);

        cyc(0, 3'b000, 1, 7'h47, 0);
        cyc(1, 3'b000, 0, 7'h00, 0);
        check("R6 masked source", 32'(req), 32'h0);
        check("R4 still pending", 32'(rd), 32'h47);
        cyc(0, 3'b000, 0, 7'h00, 0);

        cyc(0, 3'b100, 1, 7'h07, 0);
        check("R9 set beats clear", 32'(rd), 32'h47);

        cyc(0, 3'b000, 0, 7'h00, 1);
        check("R12 idle ack", 32'(rd), 32'h47);

        cyc(0, 3'b000, 1, 7'h4F, 0);
        cyc(1, 3'b000, 0, 7'h00, 0);
        check("R2 src2 vector", 32'(vec), 32'h0C);
        cyc(0, 3'b000, 1, 7'h4E, 0);
        check("R5 withdraw req", 32'(req), 32'h0);
        check("R11 vec zero idle", 32'(vec), 32'h00);

        // Random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            logic       ph, w, a;
            logic [2:0] p;
            logic [6:0] wd;
            ph = ($urandom % 3) == 0 ? ~phase : phase;
            p[0] = ($urandom % 9) == 0;
            p[1] = ($urandom % 7) == 0;
            p[2] = ($urandom % 6) == 0;
            w  = ($urandom % 20) == 0;
            wd = 7'($urandom);
            if (($urandom % 5) != 0) wd[0] = 1'b1;
            if (($urandom % 3) != 0) wd[3:1] = 3'b111;
            a  = req ? (($urandom % 3) == 0) : (($urandom % 25) == 0);
            if (!m_gie && (($urandom % 8) == 0)) begin
                w = 1'b1;
                wd = {m_flag, 3'b111, 1'b1};
            end
            cyc(ph, p, w, wd, a);
        end

        finish_run();
    end

endmodule